// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of an SDRAM interface. On every rising clock edge it samples the clock enable, the four command strobes, the bank select and the address. It then classifies the command and keeps an open or closed flag for each bank, along with the row that was opened there. It also follows the device through normal operation, clock suspend, power down and self refresh. It is meant as the front end of a behavioural memory model or of a protocol checker. Timing parameters, the storage array and the data path are not part of it.

Every output is registered. After the clock edge that samples a command, the outputs show the decoded command code, the bank it addressed, its auto-precharge flag, and whether the command broke a bank-state rule. A command is decoded only when the clock enable was high at the previous edge, which holds exactly when the device mode was normal. The current clock-enable level decides two things: whether a refresh encoding means auto refresh or self-refresh entry, and whether the device now leaves normal mode. A burst counter, loaded from the latched op code, tells clock suspend apart from power down. The same counter also times the closing of a bank that was accessed with auto precharge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select sampled high, the command is a deselect: `cmd_code` reads 0, `illegal` stays 0 and no bank state changes.
- R2: An activate has strobes (RAS,CAS,WE) = (0,1,1) and gives `cmd_code` 2. It opens the selected bank and latches the address as that bank's row. An activate to a bank that is already open sets `illegal` and leaves the row unchanged.
- R3: Strobes (1,0,1) give a read, with `cmd_code` 3. Strobes (1,0,0) give a write, with `cmd_code` 4. `auto_pre` copies address bit 10 for these two commands only. A read or write to a closed bank sets `illegal` and starts no burst.
- R4: Strobes (0,1,0) give a precharge. With address bit 10 low it closes only the selected bank (`cmd_code` 5). With bit 10 high it closes every bank (`cmd_code` 6).
- R5: A bank select value n addresses bit n of `bank_active` and row field n of `row_open`, which is bits n*12+11 down to n*12.
- R6: Strobes (0,0,0) give a mode register set, with `cmd_code` 7. It latches the address into `mode_reg` only when every bank is closed and no burst is running. Otherwise it sets `illegal` and keeps the old value.
- R7: Strobes (1,1,1) give a no-operation (`cmd_code` 1). Strobes (1,1,0) give a burst stop (`cmd_code` 8), which ends the running burst at once.
- R8: Burst length comes from `mode_reg` bits 2:0. The values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and 7 gives a 512-beat page. The last beat lands on the edge that is length-1 normal-mode edges after the read or write. A burst with auto precharge closes its bank on that edge, which is the command edge itself when the length is 1.
- R9: Strobes (0,0,1) give a refresh. With clock enable high it is auto refresh (`cmd_code` 9). With clock enable low it is self-refresh entry (`cmd_code` 10), and `dev_mode` becomes 3. Either form sets `illegal` if any bank is open, and an illegal self-refresh entry falls into power down.
- R10: If clock enable is low at an edge while the mode is normal, `dev_mode` changes. It becomes 1 (clock suspend) if a burst is still running after that edge, and 2 (power down) otherwise. While the mode is not normal, commands are ignored (`cmd_code` 11) and the burst is frozen. A high clock enable then returns the mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address and op code; bit 10 is the precharge modifier |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_bank | output | 2 | Bank select of the last edge |
| auto_pre | output | 1 | Read or write carried auto precharge |
| illegal | output | 1 | Last command broke a bank-state rule |
| dev_mode | output | 2 | 0 normal, 1 clock suspend, 2 power down, 3 self refresh |
| bank_active | output | 4 | One open flag per bank |
| row_open | output | 48 | Latched row per bank, 12 bits each |
| mode_reg | output | 12 | Latched mode register op code |

## Verification
The bench sweeps the burst-length codes and checks the exact edge on which an auto-precharged bank closes. A design that counted one beat too many or too few would close the bank early or late, and a design that closed it at the command edge would do so for every length instead of only for length 1. It stops a burst in the middle with clock enable low. A design that chose power down there would report mode 2 instead of 1, and a design that kept counting during the suspend would close the bank before the resumed beats were used up. It also drives a refresh with clock enable low while banks are idle and again while one is open. A decoder that looked only at the strobes would report auto refresh, and a design that skipped the idle check would enter self refresh with a row still open.

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int NB    = 4,
  parameter int BA_W  = $clog2(NB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [BA_W-1:0]       ba,
  input  logic [ROW_W-1:0]      addr,
  output logic [3:0]            cmd_code,
  output logic [BA_W-1:0]       cmd_bank,
  output logic                  auto_pre,
  output logic                  illegal,
  output logic [1:0]            dev_mode,
  output logic [NB-1:0]         bank_active,
  output logic [NB*ROW_W-1:0]   row_open,
  output logic [ROW_W-1:0]      mode_reg
);
  localparam int CNT_W = COL_W + 1;
  localparam int AP    = 10;

  localparam logic [3:0] C_DESEL = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                         C_WR = 4'd4, C_PRE = 4'd5, C_PREA = 4'd6, C_MRS = 4'd7,
                         C_BST = 4'd8, C_AREF = 4'd9, C_SREF = 4'd10, C_IGN = 4'd11;
  localparam logic [1:0] M_NORM = 2'd0, M_SUSP = 2'd1, M_PD = 2'd2, M_SREF = 2'd3;

  function automatic logic [CNT_W-1:0] blen(input logic [2:0] code);
    case (code)
      3'd1:    blen = CNT_W'(2);
      3'd2:    blen = CNT_W'(4);
      3'd3:    blen = CNT_W'(8);
      3'd7:    blen = CNT_W'(1) << COL_W;
      default: blen = CNT_W'(1);
    endcase
  endfunction

  logic [CNT_W-1:0] burst_q, burst_n;
  logic             ap_q, ap_n;
  logic [BA_W-1:0]  apb_q, apb_n;
  logic [3:0]       kind;
  logic             bad;
  logic [NB-1:0]    bank_n, close;
  logic [1:0]       mode_n;

  wire              normal = (dev_mode == M_NORM);
  wire              busy   = (burst_q != '0);
  wire [CNT_W-1:0]  len    = blen(mode_reg[2:0]);
  wire              is_rw  = (kind == C_RD) || (kind == C_WR);

  always_comb begin
    if (!normal)   kind = C_IGN;
    else if (cs_n) kind = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  kind = C_ACT;
        3'b010:  kind = addr[AP] ? C_PREA : C_PRE;
        3'b101:  kind = C_RD;
        3'b100:  kind = C_WR;
        3'b000:  kind = C_MRS;
        3'b111:  kind = C_NOP;
        3'b110:  kind = C_BST;
        default: kind = cke ? C_AREF : C_SREF;
      endcase
    end
  end

  always_comb begin
    case (kind)
      C_ACT:                bad = bank_active[ba];
      C_RD, C_WR:           bad = !bank_active[ba];
      C_MRS, C_AREF, C_SREF: bad = (|bank_active) || busy;
      default:              bad = 1'b0;
    endcase
  end

  always_comb begin
    burst_n = burst_q;
    ap_n    = ap_q;
    apb_n   = apb_q;
    close   = '0;
    bank_n  = bank_active;
    if (normal) begin
      if (is_rw && !bad) begin
        if (busy && ap_q && apb_q != ba) close[apb_q] = 1'b1;
        burst_n = len - CNT_W'(1);
        ap_n    = addr[AP] && (len != CNT_W'(1));
        apb_n   = ba;
        if (addr[AP] && len == CNT_W'(1)) close[ba] = 1'b1;
      end else if (kind == C_BST) begin
        burst_n = '0;
        ap_n    = 1'b0;
        if (ap_q) close[apb_q] = 1'b1;
      end else if (busy) begin
        burst_n = burst_q - CNT_W'(1);
        if (burst_q == CNT_W'(1)) begin
          ap_n = 1'b0;
          if (ap_q) close[apb_q] = 1'b1;
        end
      end
      if (kind == C_ACT && !bad) bank_n[ba] = 1'b1;
      if (kind == C_PRE) begin
        bank_n[ba] = 1'b0;
        if (apb_q == ba) ap_n = 1'b0;
      end
      if (kind == C_PREA) begin
        bank_n = '0;
        ap_n   = 1'b0;
      end
      bank_n = bank_n & ~close;
    end
  end

  always_comb begin
    if (normal) begin
      if (cke)                          mode_n = M_NORM;
      else if (kind == C_SREF && !bad)  mode_n = M_SREF;
      else if (burst_n != '0)           mode_n = M_SUSP;
      else                              mode_n = M_PD;
    end else begin
      mode_n = cke ? M_NORM : dev_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code    <= C_DESEL;
      cmd_bank    <= '0;
      auto_pre    <= 1'b0;
      illegal     <= 1'b0;
      dev_mode    <= M_NORM;
      bank_active <= '0;
      row_open    <= '0;
      mode_reg    <= '0;
      burst_q     <= '0;
      ap_q        <= 1'b0;
      apb_q       <= '0;
    end else begin
      cmd_code    <= kind;
      cmd_bank    <= ba;
      auto_pre    <= is_rw && addr[AP];
      illegal     <= bad;
      dev_mode    <= mode_n;
      bank_active <= bank_n;
      burst_q     <= burst_n;
      ap_q        <= ap_n;
      apb_q       <= apb_n;
      if (kind == C_MRS && !bad) mode_reg <= addr;
      if (kind == C_ACT && !bad) row_open[ba*ROW_W +: ROW_W] <= addr;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_chk #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd_code,
  input logic [BA_W-1:0] cmd_bank,
  input logic            auto_pre,
  input logic            illegal,
  input logic [1:0]      dev_mode,
  input logic [NB-1:0]   bank_active
);
  AST_DESEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 4'd0 |-> !illegal && !auto_pre); // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd2 && !illegal) |-> bank_active[cmd_bank]); // R2
  AST_AP_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd_code == 4'd3 || cmd_code == 4'd4)); // R3
  AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 4'd6 |-> bank_active == '0); // R4
  AST_SREF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_mode == 2'd3 |-> bank_active == '0); // R9
  AST_SREF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd10 && !illegal) |-> dev_mode == 2'd3); // R9
  AST_IGN_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_mode) != 2'd0 |-> cmd_code == 4'd11); // R10
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NB(NB), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .auto_pre(auto_pre), .illegal(illegal), .dev_mode(dev_mode),
  .bank_active(bank_active)
);

// File: tb/tb_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_tracker;
  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank, dev_mode;
  logic auto_pre, illegal;
  logic [3:0] bank_active;
  logic [47:0] row_open;
  logic [11:0] mode_reg;
  int nchk = 0, nerr = 0;

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_PRE = 4'b0010,
                         K_RD = 4'b0101, K_WR = 4'b0100, K_MRS = 4'b0000,
                         K_BST = 4'b0110, K_REF = 4'b0001, K_DES = 4'b1000;

  sdram_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .auto_pre(auto_pre), .illegal(illegal),
    .dev_mode(dev_mode), .bank_active(bank_active), .row_open(row_open),
    .mode_reg(mode_reg)
  );

  always #4 clk = ~clk;

  task automatic op(input logic k, input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("reset cmd_code", cmd_code, 0);
    chk("reset dev_mode", dev_mode, 0);
    chk("reset bank_active", bank_active, 0);
    chk("reset illegal", illegal, 0);

    // R2 / R5: open each bank with its own row
    for (int b = 0; b < 4; b++) begin
      op(1, K_ACT, 2'(b), 12'(12'h100 + b * 17));
      chk("R2 act code", cmd_code, 2);
      chk("R2 act legal", illegal, 0);
      chk("R5 bank bits", bank_active, (1 << (b + 1)) - 1);
      chk("R5 row field", row_open[b*12 +: 12], 12'h100 + b * 17);
    end
    op(1, K_ACT, 2'd2, 12'h7ff);
    chk("R2 reopen illegal", illegal, 1);
    chk("R2 row kept", row_open[24 +: 12], 12'h100 + 34);

    op(1, K_DES, 2'd1, 12'h000);
    chk("R1 deselect code", cmd_code, 0);
    chk("R1 deselect no change", bank_active, 15);
    chk("R1 deselect legal", illegal, 0);

    op(1, K_RD, 2'd3, 12'h000);
    chk("R3 read code", cmd_code, 3);
    chk("R3 read no ap", auto_pre, 0);
    op(1, K_WR, 2'd0, 12'h400);
    chk("R3 write code", cmd_code, 4);
    chk("R3 write ap", auto_pre, 1);
    chk("R8 len1 ap closes at cmd edge", bank_active, 4'b1110);

    op(1, K_PRE, 2'd1, 12'h000);
    chk("R4 single precharge", bank_active, 4'b1100);
    chk("R4 single code", cmd_code, 5);
    op(1, K_RD, 2'd1, 12'h000);
    chk("R3 read closed bank illegal", illegal, 1);
    op(1, K_PRE, 2'd0, 12'h400);
    chk("R4 all precharge code", cmd_code, 6);
    chk("R4 all precharge", bank_active, 0);

    op(1, K_ACT, 2'd0, 12'h001);
    op(1, K_MRS, 2'd0, 12'h003);
    chk("R6 mrs with open bank illegal", illegal, 1);
    chk("R6 mrs kept", mode_reg, 0);
    op(1, K_PRE, 2'd0, 12'h000);
    op(1, K_MRS, 2'd0, 12'h033);
    chk("R6 mrs code", cmd_code, 7);
    chk("R6 mrs latched", mode_reg, 12'h033);

    // R8: burst length sweep with auto precharge
    for (int c = 0; c < 4; c++) begin
      int L;
      L = 1 << c;
      op(1, K_MRS, 2'd0, 12'(c));
      op(1, K_ACT, 2'(c), 12'h0aa);
      op(1, K_RD, 2'(c), 12'h400);
      chk("R8 bank at cmd edge", int'(bank_active[c]), (L > 1) ? 1 : 0);
      for (int i = 1; i < L; i++) begin
        op(1, K_NOP, 2'd0, 12'h000);
        chk("R8 bank during burst", int'(bank_active[c]), (i < L - 1) ? 1 : 0);
      end
    end

    // R7: full page burst stopped early
    op(1, K_MRS, 2'd0, 12'h007);
    op(1, K_ACT, 2'd2, 12'h055);
    op(1, K_RD, 2'd2, 12'h400);
    for (int i = 0; i < 10; i++) op(1, K_NOP, 2'd0, 12'h000);
    chk("R7 nop code", cmd_code, 1);
    chk("R8 page still open", int'(bank_active[2]), 1);
    op(1, K_BST, 2'd0, 12'h000);
    chk("R7 burst stop code", cmd_code, 8);
    chk("R7 stop closes ap bank", bank_active, 0);

    // R9: refresh forms
    op(1, K_REF, 2'd0, 12'h000);
    chk("R9 auto refresh code", cmd_code, 9);
    chk("R9 auto refresh mode", dev_mode, 0);
    op(0, K_REF, 2'd0, 12'h000);
    chk("R9 self refresh code", cmd_code, 10);
    chk("R9 self refresh mode", dev_mode, 3);
    op(0, K_ACT, 2'd1, 12'h123);
    chk("R10 ignored in self refresh", cmd_code, 11);
    chk("R10 no open in self refresh", bank_active, 0);
    op(1, K_NOP, 2'd0, 12'h000);
    chk("R10 self refresh exit", dev_mode, 0);
    op(1, K_ACT, 2'd1, 12'h123);
    chk("R10 decode after exit", bank_active, 4'b0010);
    op(1, K_REF, 2'd0, 12'h000);
    chk("R9 refresh with open bank illegal", illegal, 1);
    op(0, K_REF, 2'd0, 12'h000);
    chk("R9 bad self refresh illegal", illegal, 1);
    chk("R9 bad self refresh to power down", dev_mode, 2);
    op(1, K_NOP, 2'd0, 12'h000);
    op(1, K_PRE, 2'd1, 12'h000);

    // R10: power down when idle
    op(0, K_NOP, 2'd0, 12'h000);
    chk("R10 power down", dev_mode, 2);
    op(0, K_NOP, 2'd0, 12'h000);
    chk("R10 power down hold", dev_mode, 2);
    chk("R10 ignored in power down", cmd_code, 11);
    op(1, K_NOP, 2'd0, 12'h000);
    chk("R10 power down exit", dev_mode, 0);

    // R10: clock suspend freezes an 8-beat burst
    op(1, K_MRS, 2'd0, 12'h003);
    op(1, K_ACT, 2'd1, 12'h0f0);
    op(1, K_RD, 2'd1, 12'h400);
    op(1, K_NOP, 2'd0, 12'h000);
    op(0, K_NOP, 2'd0, 12'h000);
    chk("R10 suspend in burst", dev_mode, 1);
    for (int i = 0; i < 3; i++) begin
      op(0, K_NOP, 2'd0, 12'h000);
      chk("R10 suspend hold", dev_mode, 1);
      chk("R10 bank held in suspend", int'(bank_active[1]), 1);
    end
    op(1, K_NOP, 2'd0, 12'h000);
    chk("R10 suspend exit", dev_mode, 0);
    for (int i = 1; i <= 5; i++) begin
      op(1, K_NOP, 2'd0, 12'h000);
      chk("R10 resumed burst", int'(bank_active[1]), (i < 5) ? 1 : 0);
    end

    finish_run();
  end
endmodule